// File: doc/BRIEF.md
# One-in-Twenty-Five Sample Decimator

This block thins a stream of 36-bit filtered samples by a fixed ratio. Out of every 25 samples it accepts, it forwards exactly one and discards the rest. It sits between an upstream filter and a downstream rounding stage. Both sides use the same three-wire handshake: valid, ready and acknowledge.

On the upstream side the block acts as a slave. It raises `in_ready` when it can take a sample. A sample is captured on a rising clock edge where `en`, `in_valid` and `in_ready` are all high. On the next cycle the block pulses `in_ack` for one cycle. This happens for every captured sample, whether it is kept or thrown away, so the filter never stalls on discarded data.

On the downstream side the block acts as a master. It presents a kept sample with `out_valid` once the receiver shows `out_ready`. It holds the sample until the receiver answers with `out_ack`. While a kept sample is outstanding, no new input is taken.

Top module: `sample_decimator`

## Requirements
- R1: The block keeps exactly one of every 25 captured samples. A phase counter steps on each capture, and the sample captured at phase 0 is the one kept.
- R2: After reset, `in_ready` is 1, `in_ack` is 0 and `out_valid` is 0. The first sample captured after reset is kept.
- R3: A kept sample appears on `out_data` bit for bit as it was captured. `out_data` and `out_valid` stay constant until an `out_ack` is accepted, and `out_valid` falls on the cycle after that acknowledge.
- R4: Each captured sample, kept or dropped, gets `in_ack` high for exactly one cycle. That cycle is the one right after the capture edge.
- R5: `in_ready` is low during the acknowledge cycle. It stays low for as long as a kept sample is waiting or presented downstream. After a dropped sample it returns to high on the cycle after the acknowledge.
- R6: `out_valid` rises only after `out_ready` was high on the previous edge. While `out_ready` is low, a kept sample waits with `out_valid` low.
- R7: While `en` is low, nothing changes: no capture occurs, the phase counter does not move, and an `out_ack` is ignored. All outputs hold their values.
- R8: Reset is synchronous and active high. Applied in the middle of a stream, it returns the phase to 0.
- R9: A dropped sample never shows up downstream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Synchronous enable, active high |
| in_valid | input | 1 | Upstream sample present |
| in_data | input | 36 | Upstream sample |
| in_ready | output | 1 | Block can capture a sample |
| in_ack | output | 1 | One-cycle acknowledge of a captured sample |
| out_ready | input | 1 | Downstream can take a sample |
| out_ack | input | 1 | Downstream acknowledge of the presented sample |
| out_valid | output | 1 | Kept sample present on out_data |
| out_data | output | 36 | Kept sample |

## Verification
The assertions make some assumptions about the neighbours on each side.

- Upstream is expected to hold `in_valid` and `in_data` steady until it sees `in_ack`, and to drop `in_valid` after that.
- Downstream is expected to pulse `out_ack` for a single cycle, and only while `out_valid` is high.

The stimulus stays inside these rules. The bench drives and releases every input on the falling edge, and it deasserts `in_valid` in the acknowledge cycle. Its responder raises `out_ack` only after it has observed `out_valid`. `out_ready` and `en` are toggled only while no acknowledge is in flight, except in the one directed test that checks an acknowledge is ignored while the block is disabled.

// File: rtl/dec_pkg.sv
package dec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ACK_DROP = 3'd1,
    ST_ACK_KEEP = 3'd2,
    ST_WAIT     = 3'd3,
    ST_SEND     = 3'd4
  } hs_state_t;

  function automatic int phase_width(input int ratio);
    return (ratio > 1) ? $clog2(ratio) : 1;
  endfunction
endpackage

// File: rtl/dec_phase_ctr.sv
module dec_phase_ctr #(
  parameter int RATIO = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic at_zero
);
  localparam int CW = dec_pkg::phase_width(RATIO);
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst)
      phase <= '0;
    else if (step)
      phase <= (phase == LAST) ? '0 : phase + 1'b1;
  end

  assign at_zero = (phase == '0);

  assert_phase_range_R1: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST);
  assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (step && phase == LAST) |=> at_zero);
  assert_phase_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(phase));
endmodule

// File: rtl/dec_hold_reg.sv
module dec_hold_reg #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (load)
      dout <= din;
  end
endmodule

// File: rtl/dec_hs_fsm.sv
module dec_hs_fsm
  import dec_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic in_valid,
  input  logic keep,
  input  logic out_ready,
  input  logic out_ack,
  output logic in_ready,
  output logic in_ack,
  output logic out_valid,
  output logic capture
);
  hs_state_t state, nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:     if (in_valid) nxt = keep ? ST_ACK_KEEP : ST_ACK_DROP;
      ST_ACK_DROP: nxt = ST_IDLE;
      ST_ACK_KEEP: nxt = out_ready ? ST_SEND : ST_WAIT;
      ST_WAIT:     if (out_ready) nxt = ST_SEND;
      ST_SEND:     if (out_ack) nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      in_ready  <= 1'b1;
      in_ack    <= 1'b0;
      out_valid <= 1'b0;
    end else if (en) begin
      state     <= nxt;
      in_ready  <= (nxt == ST_IDLE);
      in_ack    <= (nxt == ST_ACK_DROP) || (nxt == ST_ACK_KEEP);
      out_valid <= (nxt == ST_SEND);
    end
  end

  assign capture = en && in_valid && in_ready;

  assert_ack_follows_capture_R4: assert property (@(posedge clk) disable iff (rst)
    capture |=> in_ack);
  assert_ack_single_R4: assert property (@(posedge clk) disable iff (rst)
    (in_ack && en) |=> !in_ack);
  assert_ready_low_ack_R5: assert property (@(posedge clk) disable iff (rst)
    in_ack |-> !in_ready);
  assert_ready_low_send_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);
  assert_valid_after_ready_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(out_ready));
  assert_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(out_valid) && $stable(in_ready) && $stable(in_ack)));
endmodule

// File: rtl/sample_decimator.sv
module sample_decimator #(
  parameter int W     = 36,
  parameter int RATIO = 25
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         in_ack,
  input  logic         out_ready,
  input  logic         out_ack,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  logic capture;
  logic keep;

  dec_phase_ctr #(.RATIO(RATIO)) phase_i (
    .clk     (clk),
    .rst     (rst),
    .step    (capture),
    .at_zero (keep)
  );

  dec_hs_fsm fsm_i (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .in_valid  (in_valid),
    .keep      (keep),
    .out_ready (out_ready),
    .out_ack   (out_ack),
    .in_ready  (in_ready),
    .in_ack    (in_ack),
    .out_valid (out_valid),
    .capture   (capture)
  );

  dec_hold_reg #(.W(W)) hold_i (
    .clk  (clk),
    .load (capture && keep),
    .din  (in_data),
    .dout (out_data)
  );

  assert_data_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !(out_ack && en)) |=> (out_valid && $stable(out_data)));
  assert_valid_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ack && en) |=> !out_valid);
  assert_drop_hidden_R9: assert property (@(posedge clk) disable iff (rst)
    (capture && !keep) |=> !out_valid);
endmodule

// File: tb/sample_decimator_tb_top.sv
`timescale 1ns/1ps
module sample_decimator_tb_top;
  localparam int W = 36;
  localparam int RATIO = 25;
  // per row: sample count, downstream ack stall cycles
  localparam int VEC [0:5][0:1] = '{
    '{26, 0}, '{24, 2}, '{1, 0}, '{25, 3}, '{30, 1}, '{4, 0}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, en = 1'b1, in_valid = 1'b0, out_ready = 1'b1, out_ack = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready, in_ack, out_valid;
  logic [W-1:0] out_data;

  sample_decimator #(.W(W), .RATIO(RATIO)) dut_i (
    .clk(clk), .rst(rst), .en(en), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .in_ack(in_ack), .out_ready(out_ready),
    .out_ack(out_ack), .out_valid(out_valid), .out_data(out_data)
  );

  int n_chk = 0, n_bad = 0, gidx = 0, qwr = 0, qrd = 0, n_out = 0, stall = 0;
  bit auto_rsp = 1'b1, done = 1'b0;
  logic [W-1:0] expq [0:255];

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    gidx = 0; qwr = 0; qrd = 0;
  endtask

  task automatic send(input logic [W-1:0] d);
    @(negedge clk); in_valid = 1'b1; in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    chk(in_ack === 1'b1, "R4 ack in cycle after capture", W'(in_ack), 1);
    chk(in_ready === 1'b0, "R5 ready low in ack cycle", W'(in_ready), 0);
    in_valid = 1'b0;
    if (gidx % RATIO == 0) begin expq[qwr[7:0]] = d; qwr++; end
    gidx++;
    @(negedge clk);
    chk(in_ack === 1'b0, "R4 ack lasts one cycle", W'(in_ack), 0);
  endtask

  // downstream responder
  initial begin
    forever begin
      @(negedge clk);
      if (auto_rsp && out_valid === 1'b1 && !rst) begin
        logic [W-1:0] seen;
        seen = out_data;
        n_out++;
        if (qrd >= qwr) chk(1'b0, "R9 unexpected output", seen, 0);
        else begin
          chk(seen === expq[qrd[7:0]], "R1 kept sample value", seen, expq[qrd[7:0]]);
          qrd++;
        end
        chk(in_ready === 1'b0, "R5 ready low while presenting", W'(in_ready), 0);
        for (int s = 0; s < stall; s++) begin
          @(negedge clk);
          chk(out_valid === 1'b1 && out_data === seen, "R3 hold until ack", out_data, seen);
        end
        out_ack = 1'b1;
        @(negedge clk);
        out_ack = 1'b0;
        chk(out_valid === 1'b0, "R3 valid drops after ack", W'(out_valid), 0);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk(in_ready === 1'b1, "R2 reset ready", W'(in_ready), 1);
    chk(in_ack === 1'b0, "R2 reset ack", W'(in_ack), 0);
    chk(out_valid === 1'b0, "R2 reset valid", W'(out_valid), 0);

    // table walk: R1, R3, R4, R5, R9
    for (int v = 0; v < 6; v++) begin
      stall = VEC[v][1];
      for (int k = 0; k < VEC[v][0]; k++)
        send({4'h5, 32'(gidx * 7919 + v * 13 + 1)});
      repeat (12) @(negedge clk);
      chk(n_out == qwr, "R1 output count after vector", W'(n_out), W'(qwr));
    end
    stall = 0;

    // R8: mid-stream reset returns phase to 0
    begin
      int base;
      do_reset();
      send(36'h1_0000_0001);
      send(36'h1_0000_0002);
      send(36'h1_0000_0003);
      repeat (6) @(negedge clk);
      do_reset();
      base = n_out;
      send(36'h8_0000_0008);
      repeat (6) @(negedge clk);
      chk(n_out == base + 1, "R8 first sample after reset kept", W'(n_out), W'(base + 1));
    end

    // R6: out_ready low keeps kept sample waiting
    begin
      int base;
      do_reset();
      base = n_out;
      out_ready = 1'b0;
      send(36'h6_6666_6666);
      repeat (5) @(negedge clk);
      chk(out_valid === 1'b0, "R6 no valid without ready", W'(out_valid), 0);
      chk(in_ready === 1'b0, "R5 ready low while waiting", W'(in_ready), 0);
      out_ready = 1'b1;
      repeat (6) @(negedge clk);
      chk(n_out == base + 1, "R6 sent once ready", W'(n_out), W'(base + 1));
    end

    // R7: enable low blocks capture and phase movement
    begin
      int base;
      base = n_out;
      en = 1'b0;
      @(negedge clk); in_valid = 1'b1; in_data = 36'hF_DEAD_BEEF;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        chk(in_ack === 1'b0, "R7 no ack while disabled", W'(in_ack), 0);
      end
      in_valid = 1'b0;
      en = 1'b1;
      for (int k = 0; k < RATIO; k++) send({4'h7, 32'(k + 100)});
      repeat (6) @(negedge clk);
      chk(n_out == base + 1, "R7 phase unchanged by disabled cycles", W'(n_out), W'(base + 1));
    end

    // R7: out_ack ignored while disabled
    begin
      do_reset();
      auto_rsp = 1'b0;
      send(36'h3_3333_3333);
      @(negedge clk);
      chk(out_valid === 1'b1, "R3 kept sample presented", W'(out_valid), 1);
      en = 1'b0; out_ack = 1'b1;
      @(negedge clk);
      out_ack = 1'b0;
      @(negedge clk);
      chk(out_valid === 1'b1, "R7 ack ignored while disabled", W'(out_valid), 1);
      chk(out_data === 36'h3_3333_3333, "R7 data held while disabled", out_data, 36'h3_3333_3333);
      en = 1'b1; out_ack = 1'b1;
      @(negedge clk);
      out_ack = 1'b0;
      chk(out_valid === 1'b0, "R3 valid drops after enabled ack", W'(out_valid), 0);
      chk(in_ready === 1'b1, "R5 ready returns after ack", W'(in_ready), 1);
      qrd++;
      auto_rsp = 1'b1;
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule